// File: doc/BRIEF.md
# Speaker Sample Buffer with Gap Concealment

This block feeds a speaker DAC from a host that writes 16-bit two's complement samples through one write-only register address. Samples go into a 16-entry first-in first-out store. Each pulse of the selected sample-rate tick takes one sample from the store into the registered DAC output. A single select bit chooses between a modem-rate tick and a handset-rate tick.

When a tick finds the store empty, the block does not emit garbage and does not raise a flag. It keeps presenting the sample it last output for up to 16 consecutive empty ticks. After that it presents the midscale code, 16'h0000, until real data arrives again. This prevents a click on a short gap and prevents a sustained DC level on a long one.

A write that arrives while the store is full is dropped without any trace. The host has no full, empty or error status to read.

Top module: `spk_fifo_conceal`

## Requirements
- R1: A sample is stored only when `host_wr` is high and `host_addr` equals the write address (default 4'hA). A write to any other address has no effect on the output sequence.
- R2: Stored samples reach `dac_sample` in the order they were written, and the store holds up to 16 of them.
- R3: A write is dropped when the store already holds 16 samples at the start of that cycle, even if a tick removes a sample in the same cycle. The stored contents stay unchanged.
- R4: On a selected tick with the store empty, `dac_sample` keeps its previous value. This holds for the first 16 consecutive empty ticks.
- R5: On the 17th consecutive empty tick, and on every later one, `dac_sample` becomes 16'h0000 (midscale) until data is stored.
- R6: With `rate_sel`=0 only `modem_tick` takes samples. With `rate_sel`=1 only `handset_tick` takes samples. The tick that is not selected has no effect.
- R7: `dac_sample` changes only on the clock edge that samples a selected tick, and it keeps its value in every other cycle.
- R8: A tick that finds data clears the count of consecutive empty ticks. A later gap therefore again repeats the last sample 16 times before it falls to midscale.
- R9: If a write and a selected tick happen in the same cycle while the store is empty, the tick counts as an empty tick. The new sample is output on the next selected tick.
- R10: Synchronous active-high `rst` empties the store, clears the empty-tick count and sets `dac_sample` to 16'h0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host write strobe |
| host_addr | input | 4 | Host register address |
| host_wdata | input | 16 | Sample written by the host |
| rate_sel | input | 1 | Tick select: 0 = modem tick, 1 = handset tick |
| modem_tick | input | 1 | Modem sample-rate pulse |
| handset_tick | input | 1 | Handset sample-rate pulse |
| dac_sample | output | 16 | Registered sample sent to the speaker DAC |

## Verification
A wrong fill level or pointer shows up at `dac_sample` one clock after the next selected tick, either as a sample out of order or as a repeated sample where fresh data was due. An empty-tick count that is off by one moves the fall to midscale by exactly one tick. The bench therefore checks long gaps at tick 16 and tick 17. A mistake in the full check only becomes visible when the store is read out: a dropped write then reappears, or an accepted one is missing. So each fill-to-full case is followed by a complete drain.

// File: rtl/spk_pkg.sv
package spk_pkg;
  // Outcome of one cycle on the read side of the sample buffer.
  typedef enum logic [1:0] {
    RD_IDLE = 2'd0,  // no selected tick this cycle
    RD_DATA = 2'd1,  // tick found a stored sample
    RD_HOLD = 2'd2,  // tick on empty store, repeat previous sample
    RD_MID  = 2'd3   // tick on empty store, hold budget spent
  } rd_kind_e;
endpackage

// File: rtl/spk_host_decode.sv
module spk_host_decode #(
  parameter int ADDR_W  = 4,
  parameter int WR_ADDR = 10
) (
  input  logic              host_wr,
  input  logic [ADDR_W-1:0] host_addr,
  output logic              wr_hit
);
  localparam logic [ADDR_W-1:0] MATCH = ADDR_W'(WR_ADDR);

  assign wr_hit = host_wr && (host_addr == MATCH);
endmodule

// File: rtl/spk_rate_select.sv
module spk_rate_select #(
  parameter int N_SRC = 2
) (
  input  logic [N_SRC-1:0]         ticks,
  input  logic [$clog2(N_SRC)-1:0] sel,
  output logic                     pull
);
  assign pull = ticks[sel];
endmodule

// File: rtl/spk_sample_fifo.sv
module spk_sample_fifo #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 16
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         push,
  input  logic [DATA_W-1:0]            wdata,
  input  logic                         pop,
  output logic [DATA_W-1:0]            rdata,
  output logic                         empty,
  output logic                         full,
  output logic [$clog2(DEPTH+1)-1:0]   level
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int LVL_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic [LVL_W-1:0]  fill;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  // Storage: write port only, no reset, so it maps to RAM.
  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      fill   <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      unique case ({push, pop})
        2'b10:   fill <= fill + 1'b1;
        2'b01:   fill <= fill - 1'b1;
        default: fill <= fill;
      endcase
    end
  end

  assign rdata = mem[rd_ptr];
  assign empty = (fill == '0);
  assign full  = (fill == LVL_W'(DEPTH));
  assign level = fill;
endmodule

// File: rtl/spk_conceal.sv
module spk_conceal
  import spk_pkg::*;
#(
  parameter int              DATA_W     = 16,
  parameter int              HOLD_LIMIT = 16,
  parameter logic [DATA_W-1:0] MIDSCALE = '0
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              pull,
  input  logic                              empty,
  input  logic [DATA_W-1:0]                 rdata,
  output logic                              pop,
  output logic [$clog2(HOLD_LIMIT+1)-1:0]   ucnt,
  output logic [DATA_W-1:0]                 sample
);
  localparam int CNT_W = $clog2(HOLD_LIMIT + 1);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(HOLD_LIMIT);

  rd_kind_e kind;

  always_comb begin
    if (!pull)            kind = RD_IDLE;
    else if (!empty)      kind = RD_DATA;
    else if (ucnt < LIMIT) kind = RD_HOLD;
    else                  kind = RD_MID;
  end

  assign pop = (kind == RD_DATA);

  // The output register doubles as the "last sample" store.
  always_ff @(posedge clk) begin
    if (rst) begin
      sample <= MIDSCALE;
      ucnt   <= '0;
    end else begin
      unique case (kind)
        RD_DATA: begin
          sample <= rdata;
          ucnt   <= '0;
        end
        RD_HOLD: ucnt   <= ucnt + 1'b1;
        RD_MID:  sample <= MIDSCALE;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/spk_fifo_conceal.sv
module spk_fifo_conceal #(
  parameter int DATA_W     = 16,
  parameter int DEPTH      = 16,
  parameter int HOLD_LIMIT = 16,
  parameter int ADDR_W     = 4,
  parameter int WR_ADDR    = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_wr,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  input  logic              rate_sel,
  input  logic              modem_tick,
  input  logic              handset_tick,
  output logic [DATA_W-1:0] dac_sample
);
  localparam int LVL_W = $clog2(DEPTH + 1);
  localparam int CNT_W = $clog2(HOLD_LIMIT + 1);

  logic              wr_hit, push, pop, pull, empty, full;
  logic [DATA_W-1:0] rdata;
  logic [LVL_W-1:0]  level;
  logic [CNT_W-1:0]  ucnt;

  spk_host_decode #(.ADDR_W(ADDR_W), .WR_ADDR(WR_ADDR)) u_dec (
    .host_wr   (host_wr),
    .host_addr (host_addr),
    .wr_hit    (wr_hit)
  );

  spk_rate_select #(.N_SRC(2)) u_rate (
    .ticks (  {handset_tick, modem_tick}),
    .sel   (rate_sel),
    .pull  (pull)
  );

  // Full is judged on the level at the start of the cycle.
  assign push = wr_hit && !full;

  spk_sample_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
    .clk   (clk),
    .rst   (rst),
    .push  (push),
    .wdata (host_wdata),
    .pop   (pop),
    .rdata (rdata),
    .empty (empty),
    .full  (full),
    .level (level)
  );

  spk_conceal #(.DATA_W(DATA_W), .HOLD_LIMIT(HOLD_LIMIT)) u_conceal (
    .clk    (clk),
    .rst    (rst),
    .pull   (pull),
    .empty  (empty),
    .rdata  (rdata),
    .pop    (pop),
    .ucnt   (ucnt),
    .sample (dac_sample)
  );
endmodule

// File: rtl/spk_fifo_conceal_chk.sv
module spk_fifo_conceal_chk #(
  parameter int DATA_W     = 16,
  parameter int DEPTH      = 16,
  parameter int HOLD_LIMIT = 16
) (
  input logic                             clk,
  input logic                             rst,
  input logic                             wr_hit,
  input logic                             pull,
  input logic                             pop,
  input logic                             empty,
  input logic [$clog2(DEPTH+1)-1:0]       level,
  input logic [$clog2(HOLD_LIMIT+1)-1:0]  ucnt,
  input logic [DATA_W-1:0]                dac_sample
);
  localparam int LVL_W = $clog2(DEPTH + 1);
  localparam int CNT_W = $clog2(HOLD_LIMIT + 1);

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
    level <= LVL_W'(DEPTH));

  p_full_drop_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_hit && level == LVL_W'(DEPTH) && !pop) |=> level == LVL_W'(DEPTH));

  p_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (pull && empty && ucnt < CNT_W'(HOLD_LIMIT)) |=> $stable(dac_sample));

  p_midscale_r5: assert property (@(posedge clk) disable iff (rst)
    (pull && empty && ucnt == CNT_W'(HOLD_LIMIT)) |=> dac_sample == '0);

  p_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    !pull |=> $stable(dac_sample));

  p_count_clear_r8: assert property (@(posedge clk) disable iff (rst)
    pop |=> ucnt == '0);

  p_no_empty_pop_r9: assert property (@(posedge clk) disable iff (rst)
    pop |-> !empty);
endmodule

bind spk_fifo_conceal spk_fifo_conceal_chk #(
  .DATA_W(DATA_W), .DEPTH(DEPTH), .HOLD_LIMIT(HOLD_LIMIT)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .wr_hit     (wr_hit),
  .pull       (pull),
  .pop        (pop),
  .empty      (empty),
  .level      (level),
  .ucnt       (ucnt),
  .dac_sample (dac_sample)
);

// File: tb/tb_spk_fifo_conceal.sv
module tb_spk_fifo_conceal;
  localparam int DW    = 16;
  localparam int DEPTH = 16;
  localparam int HOLD  = 16;
  localparam int AW    = 4;
  localparam logic [AW-1:0] WADDR = 4'hA;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          host_wr = 1'b0;
  logic [AW-1:0] host_addr = '0;
  logic [DW-1:0] host_wdata = '0;
  logic          rate_sel = 1'b0;
  logic          modem_tick = 1'b0;
  logic          handset_tick = 1'b0;
  logic [DW-1:0] dac_sample;

  always #2 clk = ~clk;

  spk_fifo_conceal dut (
    .clk(clk), .rst(rst), .host_wr(host_wr), .host_addr(host_addr),
    .host_wdata(host_wdata), .rate_sel(rate_sel), .modem_tick(modem_tick),
    .handset_tick(handset_tick), .dac_sample(dac_sample)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  // Reference model built from the requirements.
  logic [DW-1:0] mq[$];
  logic [DW-1:0] m_out = '0;
  int            m_uc  = 0;

  function automatic void model_step(bit wr, logic [AW-1:0] a, logic [DW-1:0] d, bit pull);
    bit room = (mq.size() < DEPTH);
    if (pull) begin
      if (mq.size() > 0) begin
        m_out = mq.pop_front();
        m_uc  = 0;
      end else if (m_uc < HOLD) begin
        m_uc++;
      end else begin
        m_out = '0;
      end
    end
    if (wr && a == WADDR && room) mq.push_back(d);
  endfunction

  task automatic check(string tag, logic [DW-1:0] exp);
    n_cmp++;
    if (dac_sample !== exp) begin
      n_bad++;
      $display("FAIL %s: dac_sample=%h expected %h", tag, dac_sample, exp);
    end
  endtask

  // One clock cycle: drive, clock, model, compare at the falling edge.
  task automatic cyc(bit wr, logic [AW-1:0] a, logic [DW-1:0] d,
                     bit ta, bit tb, bit sel, string tag);
    host_wr = wr; host_addr = a; host_wdata = d;
    modem_tick = ta; handset_tick = tb; rate_sel = sel;
    @(posedge clk);
    model_step(wr, a, d, sel ? tb : ta);
    @(negedge clk);
    host_wr = 1'b0; modem_tick = 1'b0; handset_tick = 1'b0;
    check(tag, m_out);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    mq.delete();
    m_out = '0;
    m_uc  = 0;
    check("R10 reset output", 16'h0000);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1801));
    @(negedge clk);
    do_reset();

    // R10: underrun straight after reset gives midscale.
    for (int i = 0; i < 3; i++) cyc(0, WADDR, '0, 1, 0, 0, "R10 empty after reset");

    // R1: a write to a wrong address is not stored.
    cyc(1, 4'h3, 16'h7777, 0, 0, 0, "R1 wrong address");
    cyc(0, WADDR, '0, 1, 0, 0, "R1 strobe after wrong address");

    // R2, R3: fill to 16, one extra write dropped, then drain in order.
    for (int i = 0; i < DEPTH; i++) cyc(1, WADDR, 16'h1000 + DW'(i), 0, 0, 0, "R2 fill");
    cyc(1, WADDR, 16'hDEAD, 0, 0, 0, "R3 write on full");
    // R3: full at start of cycle, with a pop in the same cycle.
    cyc(1, WADDR, 16'hBEEF, 1, 0, 0, "R3 write on full with pop");
    for (int i = 0; i < DEPTH - 1; i++) cyc(0, WADDR, '0, 1, 0, 0, "R2 drain order");
    // R4: 16 empty ticks repeat the last sample; R5: then midscale.
    for (int i = 0; i < HOLD; i++) cyc(0, WADDR, '0, 1, 0, 0, "R4 repeat on underrun");
    for (int i = 0; i < 3; i++) cyc(0, WADDR, '0, 1, 0, 0, "R5 midscale after limit");

    // R6: the tick that is not selected is ignored.
    cyc(1, WADDR, 16'h4242, 0, 0, 0, "R6 load");
    cyc(0, WADDR, '0, 0, 1, 0, "R6 handset tick ignored");
    cyc(0, WADDR, '0, 1, 0, 1, "R6 modem tick ignored");
    cyc(0, WADDR, '0, 0, 1, 1, "R6 handset tick selected");
    // R7: no tick, no change.
    for (int i = 0; i < 4; i++) cyc(1, WADDR, 16'h5A5A, 0, 0, 1, "R7 idle stable");

    do_reset();
    // R9: write and tick together on an empty store.
    cyc(1, WADDR, 16'h3C3C, 1, 0, 0, "R9 same-cycle write and tick");
    cyc(0, WADDR, '0, 1, 0, 0, "R9 sample on next tick");

    // R8: gap, new data, then a fresh gap repeats 16 times again.
    for (int i = 0; i < 10; i++) cyc(0, WADDR, '0, 1, 0, 0, "R8 partial gap");
    cyc(1, WADDR, 16'h6E6E, 0, 0, 0, "R8 refill");
    cyc(0, WADDR, '0, 1, 0, 0, "R8 data after gap");
    for (int i = 0; i < HOLD + 2; i++) cyc(0, WADDR, '0, 1, 0, 0, "R8 full repeat budget");

    // Random phases, alternating write-heavy and tick-heavy.
    for (int i = 0; i < 6000; i++) begin
      bit heavy_wr = ((i / 150) % 2) == 0;
      bit sel      = ((i / 700) % 2) == 1;
      bit wr  = ($urandom % 100) < (heavy_wr ? 70 : 15);
      bit ta  = ($urandom % 100) < (heavy_wr ? 20 : 55);
      bit tb  = ($urandom % 100) < (heavy_wr ? 20 : 55);
      logic [AW-1:0] a = (($urandom % 10) == 0) ? AW'($urandom) : WADDR;
      cyc(wr, a, DW'($urandom), ta, tb, sel, "R2 R4 R5 R7 random");
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule